// File: doc/BRIEF.md
# Dual-Bus Host Register Interface

This block sits between a 16-bit host processor and the Manchester encoder and two decoders of a dual-redundant MIL-STD-1553 transceiver. The host talks to it over a strobe-qualified parallel bus. The controls are a register-select line, a read/not-write line, an active-low strobe and a channel line. There is also a bidirectional sync line that acts as a seventeenth data bit. A write with register-select low hands a word to the encoder. A read with register-select low returns the word last decoded on the chosen bus. With register-select high, the access goes to a 16-bit status and mode word. Six of its bits are host-writable configuration, and the others report the state of the two receive channels and the encoder.

The strobe is brought into the 12 MHz clock domain through a synchroniser. An access takes effect on the rising strobe edge once that edge has been synchronised. The bus fields are captured while the strobe is low, so the host must hold them for one clock period after it raises the strobe. Read data reaches the pins combinationally while the strobe is low and read is selected. Several configuration bits are ORed with hardware pins, so a system can select the bus and the sync type either in software or with wires.

Top module: `mb_host_regs`

## Requirements
- R1: Master reset clears both receive words, their sync types, received flags and error bits, and sets the configuration to transmit-disable A/B = 0, receive-enable A/B = 1, command-sync = 0, bus-B = 0. The send-ready bit reads 1 during reset, so a status read in reset returns 0x800C when both quiet inputs are low.
- R2: A status write (select high, read/not-write low) loads data bits 5:0 into the configuration. The order is bit 0 transmit-disable A, bit 1 transmit-disable B, bit 2 receive-enable A, bit 3 receive-enable B, bit 4 command-sync, bit 5 bus-B. Data bits 15:6 of such a write are ignored and leave every status bit unchanged.
- R3: A transmit write (select low, read/not-write low) produces exactly one single-cycle `tx_load` pulse. `tx_word` carries the host data unchanged, and bit 15 is the first serial data bit.
- R4: The sync type handed to the encoder is the sync pin ORed with configuration bit 4, taken at the write; 1 means command sync.
- R5: The bus handed to the encoder is the channel pin ORed with configuration bit 5, taken at the write; 1 means bus B.
- R6: A receive read (select low, read/not-write high) returns receiver B's word when the channel pin ORed with configuration bit 5 is 1, else receiver A's. During that read the sync pin is driven with the selected receiver's stored sync type.
- R7: A valid word on an enabled bus stores its data and sync type. While a bus's receive-enable bit is 0, its words and error reports are ignored.
- R8: A valid word sets that bus's received flag. Flag A shows on `rcv_flag[0]` and status bit 7, and flag B on `rcv_flag[1]` and status bit 11. A receive read clears the flag of the register it read and leaves the other flag alone.
- R9: An encoding error on an enabled bus sets its error bit (status bit 10 for A, 14 for B) without setting the received flag. `err_out` is high while either error bit is set. An error bit is cleared by the next valid word on its bus.
- R10: The data pins are released except while the strobe is low with read selected. The sync pin is released except during a receive read.
- R11: Status bit 6 reads 0, status bits 8 and 12 are the stored sync types, bits 9 and 13 follow the per-bus quiet inputs, and bit 15 follows `tx_ready` one clock later.
- R12: `tx_dis` and `rx_en` present configuration bits 1:0 and 3:2 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz master clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| h_regsel | input | 1 | 1 selects the status and mode word, 0 the transmit/receive words |
| h_rnw | input | 1 | 1 read, 0 write |
| h_strb_n | input | 1 | Active-low access strobe, action on its rising edge |
| h_chan | input | 1 | Channel pin, ORed with configuration bit 5 |
| h_data | inout | 16 | Host data bus |
| h_sync | inout | 1 | Sync type: input on transmit writes, output on receive reads |
| rx_vld | input | 2 | One-cycle pulse per bus ([0]=A, [1]=B): a valid word was decoded |
| rx_err | input | 2 | One-cycle pulse per bus: an encoding error was detected |
| rx_cmd | input | 2 | Sync type of the word reported by `rx_vld`, 1 = command |
| rx_quiet | input | 2 | Level per bus: no activity on the bus |
| rx_word_a | input | 16 | Decoded word from bus A |
| rx_word_b | input | 16 | Decoded word from bus B |
| tx_ready | input | 1 | Encoder can accept the next word |
| tx_load | output | 1 | One-cycle pulse: new word for the encoder |
| tx_word | output | 16 | Word for the encoder, bit 15 sent first |
| tx_cmd_sync | output | 1 | 1 = command sync for the loaded word |
| tx_bus_b | output | 1 | 1 = send the loaded word on bus B |
| tx_dis | output | 2 | Transmitter disables, [0]=A, [1]=B |
| rx_en | output | 2 | Receiver enables, [0]=A, [1]=B |
| rcv_flag | output | 2 | Received flags, [0]=A, [1]=B |
| err_out | output | 1 | High while either bus holds an encoding error |

## Verification
A corrupted configuration bit shows up on `tx_dis` or `rx_en` in the very next cycle. It also shows on the next status read, and it changes which receive word a read returns or which bus a transmit targets. A received flag stuck at the wrong value is visible at once on `rcv_flag` and in status bits 7 and 11. A flag cleared against the wrong register only shows when the other bus is next read or polled. A stored sync type or word held in the wrong slot stays hidden until a receive read of that bus exposes it on the data and sync pins. A random mix of accesses and bus events, checked against a bench model of every register, keeps that exposure delay short.

// File: rtl/mb_host_pkg.sv
package mb_host_pkg;
   localparam int unsigned CFG_W = 6;
   // configuration bit positions (host-visible layout)
   localparam int unsigned CB_TXDIS_A = 0;
   localparam int unsigned CB_TXDIS_B = 1;
   localparam int unsigned CB_RXEN_A  = 2;
   localparam int unsigned CB_RXEN_B  = 3;
   localparam int unsigned CB_CMDSYNC = 4;
   localparam int unsigned CB_BUSB    = 5;
   localparam logic [CFG_W-1:0] CFG_DEFAULT = 6'b001100;

   typedef struct packed {
      logic          flag;
      logic          cmd;
      logic          quiet;
      logic          err;
   } chan_stat_t;

   function automatic logic [15:0] pack_status(input logic [CFG_W-1:0] cfg,
                                               input chan_stat_t a,
                                               input chan_stat_t b,
                                               input logic ready);
      return {ready, b.err, b.quiet, b.cmd, b.flag,
              a.err, a.quiet, a.cmd, a.flag, 1'b0, cfg};
   endfunction
endpackage

// File: rtl/mb_strobe_sync.sv
module mb_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strb_n,
   output logic early_low,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mb_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], strb_n};
         prev  <= chain[STAGES-1];
      end
   end

   assign early_low = ~chain[0];
   assign rise      = chain[STAGES-1] & ~prev;

   a_r3_rise_single : assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/mb_rx_slot.sv
module mb_rx_slot #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          vld,
   input  logic          err,
   input  logic          cmd_in,
   input  logic [DW-1:0] word_in,
   input  logic          rd_clr,
   output logic [DW-1:0] word_q,
   output logic          cmd_q,
   output logic          flag_q,
   output logic          err_q
);
   logic take, bad;
   assign take = en & vld;
   assign bad  = en & err & ~vld;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         word_q <= '0;
         cmd_q  <= 1'b0;
         flag_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (take) begin
            word_q <= word_in;
            cmd_q  <= cmd_in;
            flag_q <= 1'b1;
            err_q  <= 1'b0;
         end else begin
            if (rd_clr) flag_q <= 1'b0;
            if (bad)    err_q  <= 1'b1;
         end
      end
   end

   a_r8_flag_set : assert property (@(posedge clk) disable iff (rst)
      (en && vld) |=> flag_q);
   a_r8_flag_clear : assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !(en && vld)) |=> !flag_q);
   a_r7_disabled_hold : assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(word_q) && $stable(cmd_q) && $stable(err_q)));
   a_r9_err_no_flag : assert property (@(posedge clk) disable iff (rst)
      (en && err && !vld && !rd_clr) |=> (err_q && $stable(flag_q)));
endmodule

// File: rtl/mb_host_regs.sv
module mb_host_regs
   import mb_host_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          mrst,
   input  logic          h_regsel,
   input  logic          h_rnw,
   input  logic          h_strb_n,
   input  logic          h_chan,
   inout  wire  [DW-1:0] h_data,
   inout  wire           h_sync,
   input  logic [1:0]    rx_vld,
   input  logic [1:0]    rx_err,
   input  logic [1:0]    rx_cmd,
   input  logic [1:0]    rx_quiet,
   input  logic [DW-1:0] rx_word_a,
   input  logic [DW-1:0] rx_word_b,
   input  logic          tx_ready,
   output logic          tx_load,
   output logic [DW-1:0] tx_word,
   output logic          tx_cmd_sync,
   output logic          tx_bus_b,
   output logic [1:0]    tx_dis,
   output logic [1:0]    rx_en,
   output logic [1:0]    rcv_flag,
   output logic          err_out
);
   localparam int unsigned NCH = 2;

   generate
      if (DW != 16) begin : g_bad_width
         $error("mb_host_regs: status layout needs DW == 16");
      end
   endgenerate

   // ---- strobe synchroniser and bus capture
   logic early_low, rise;
   mb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(mrst), .strb_n(h_strb_n),
      .early_low(early_low), .rise(rise));

   logic [DW-1:0] cap_data;
   logic          cap_regsel, cap_rnw, cap_chan, cap_sync;

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         cap_data   <= '0;
         cap_regsel <= 1'b0;
         cap_rnw    <= 1'b1;
         cap_chan   <= 1'b0;
         cap_sync   <= 1'b0;
      end else if (early_low) begin
         cap_data   <= h_data;
         cap_regsel <= h_regsel;
         cap_rnw    <= h_rnw;
         cap_chan   <= h_chan;
         cap_sync   <= h_sync;
      end
   end

   // ---- configuration, transmit hand-off, send-ready
   logic [CFG_W-1:0] cfg;
   logic             ready_q;
   logic             wr_cfg, wr_tx, rd_rx;

   assign wr_cfg = rise & ~cap_rnw &  cap_regsel;
   assign wr_tx  = rise & ~cap_rnw & ~cap_regsel;
   assign rd_rx  = rise &  cap_rnw & ~cap_regsel;

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         cfg         <= CFG_DEFAULT;
         ready_q     <= 1'b1;
         tx_load     <= 1'b0;
         tx_word     <= '0;
         tx_cmd_sync <= 1'b0;
         tx_bus_b    <= 1'b0;
      end else begin
         ready_q <= tx_ready;
         tx_load <= wr_tx;
         if (wr_cfg) cfg <= cap_data[CFG_W-1:0];
         if (wr_tx) begin
            tx_word     <= cap_data;
            tx_cmd_sync <= cap_sync | cfg[CB_CMDSYNC];
            tx_bus_b    <= cap_chan | cfg[CB_BUSB];
         end
      end
   end

   assign tx_dis = {cfg[CB_TXDIS_B], cfg[CB_TXDIS_A]};
   assign rx_en  = {cfg[CB_RXEN_B],  cfg[CB_RXEN_A]};

   // ---- receive slots, one per bus
   logic [DW-1:0] rxw_in [NCH];
   logic [DW-1:0] rxw_q  [NCH];
   logic [NCH-1:0] cmd_q, flag_q, err_q;
   logic           clr_sel;

   assign rxw_in[0] = rx_word_a;
   assign rxw_in[1] = rx_word_b;
   assign clr_sel   = cap_chan | cfg[CB_BUSB];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_slot
         mb_rx_slot #(.DW(DW)) u_slot (
            .clk(clk), .rst(mrst),
            .en(rx_en[c]), .vld(rx_vld[c]), .err(rx_err[c]),
            .cmd_in(rx_cmd[c]), .word_in(rxw_in[c]),
            .rd_clr(rd_rx && (clr_sel == c[0])),
            .word_q(rxw_q[c]), .cmd_q(cmd_q[c]),
            .flag_q(flag_q[c]), .err_q(err_q[c]));
      end
   endgenerate

   assign rcv_flag = flag_q;
   assign err_out  = |err_q;

   // ---- read path, combinational from the pins
   chan_stat_t    st_a, st_b;
   logic [DW-1:0] rd_data;
   logic          rd_sel, rd_oe, sync_oe;

   assign st_a   = '{flag: flag_q[0], cmd: cmd_q[0], quiet: rx_quiet[0], err: err_q[0]};
   assign st_b   = '{flag: flag_q[1], cmd: cmd_q[1], quiet: rx_quiet[1], err: err_q[1]};
   assign rd_sel = h_chan | cfg[CB_BUSB];
   assign rd_oe  = ~h_strb_n & h_rnw;
   assign sync_oe = rd_oe & ~h_regsel;

   always_comb begin
      if (h_regsel) rd_data = pack_status(cfg, st_a, st_b, ready_q);
      else          rd_data = rxw_q[rd_sel];
   end

   assign h_data = rd_oe   ? rd_data       : {DW{1'bz}};
   assign h_sync = sync_oe ? cmd_q[rd_sel] : 1'bz;

   // ---- checks
   a_r1_reset_cfg : assert property (@(posedge clk)
      mrst |=> (cfg == CFG_DEFAULT && flag_q == 2'b00 && err_q == 2'b00));
   a_r3_load_pulse : assert property (@(posedge clk) disable iff (mrst)
      tx_load |=> !tx_load);
   a_r2_cfg_only_by_write : assert property (@(posedge clk) disable iff (mrst)
      !wr_cfg |=> $stable(cfg));
   a_r9_err_out : assert property (@(posedge clk) disable iff (mrst)
      (rx_en[0] && rx_err[0] && !rx_vld[0]) |=> err_out);
endmodule

// File: tb/mb_host_regs_tb.sv
module mb_host_regs_tb_top;
   localparam time TCLK = 84ns;

   logic        clk = 1'b0;
   logic        mrst;
   logic        h_regsel, h_rnw, h_strb_n, h_chan;
   logic        tb_den, tb_sden, tb_sync;
   logic [15:0] tb_data;
   wire  [15:0] h_data;
   wire         h_sync;
   logic [1:0]  rx_vld, rx_err, rx_cmd, rx_quiet;
   logic [15:0] rx_word_a, rx_word_b;
   logic        tx_ready;
   logic        tx_load, tx_cmd_sync, tx_bus_b, err_out;
   logic [15:0] tx_word;
   logic [1:0]  tx_dis, rx_en, rcv_flag;

   int n_tests = 0;
   int n_fail  = 0;

   always #(TCLK/2) clk = ~clk;

   assign h_data = tb_den  ? tb_data : 16'hzzzz;
   assign h_sync = tb_sden ? tb_sync : 1'bz;
   pullup (h_sync);
   for (genvar g = 0; g < 16; g++) begin : g_pu
      pullup (h_data[g]);
   end

   mb_host_regs dut_i (
      .clk(clk), .mrst(mrst), .h_regsel(h_regsel), .h_rnw(h_rnw),
      .h_strb_n(h_strb_n), .h_chan(h_chan), .h_data(h_data), .h_sync(h_sync),
      .rx_vld(rx_vld), .rx_err(rx_err), .rx_cmd(rx_cmd), .rx_quiet(rx_quiet),
      .rx_word_a(rx_word_a), .rx_word_b(rx_word_b), .tx_ready(tx_ready),
      .tx_load(tx_load), .tx_word(tx_word), .tx_cmd_sync(tx_cmd_sync),
      .tx_bus_b(tx_bus_b), .tx_dis(tx_dis), .rx_en(rx_en),
      .rcv_flag(rcv_flag), .err_out(err_out));

   // ---- bench model
   logic [5:0]  m_cfg;
   logic [15:0] m_word [2];
   logic [1:0]  m_cmd, m_flag, m_err;
   logic        m_ready;

   function automatic logic [15:0] exp_status();
      return {m_ready, m_err[1], rx_quiet[1], m_cmd[1], m_flag[1],
              m_err[0], rx_quiet[0], m_cmd[0], m_flag[0], 1'b0, m_cfg};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cfg = 6'b001100; m_word[0] = '0; m_word[1] = '0;
      m_cmd = '0; m_flag = '0; m_err = '0; m_ready = 1'b1;
   endtask

   task automatic end_access();
      @(negedge clk) h_strb_n = 1'b1;
      repeat (4) @(negedge clk);
      tb_den = 1'b0; tb_sden = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [15:0] d);
      @(negedge clk);
      h_regsel = 1'b1; h_rnw = 1'b0; tb_data = d; tb_den = 1'b1;
      h_strb_n = 1'b0;
      repeat (3) @(negedge clk);
      end_access();
      m_cfg = d[5:0];
      check("R12 tx_dis", {30'd0, tx_dis}, {30'd0, m_cfg[1:0]});
      check("R12 rx_en",  {30'd0, rx_en},  {30'd0, m_cfg[3:2]});
   endtask

   task automatic read_status(input string req);
      @(negedge clk);
      h_regsel = 1'b1; h_rnw = 1'b1; h_strb_n = 1'b0;
      repeat (3) @(negedge clk);
      check(req, {16'd0, h_data}, {16'd0, exp_status()});
      check("R10 sync released on status read", {31'd0, h_sync}, 32'd1);
      end_access();
   endtask

   task automatic read_rx(input logic chan);
      logic sel;
      sel = chan | m_cfg[5];
      @(negedge clk);
      h_regsel = 1'b0; h_rnw = 1'b1; h_chan = chan; h_strb_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 rx word", {16'd0, h_data}, {16'd0, m_word[sel]});
      check("R6 rx sync pin", {31'd0, h_sync}, {31'd0, m_cmd[sel]});
      end_access();
      h_chan = 1'b0;
      m_flag[sel] = 1'b0;
      check("R8 flags after read", {30'd0, rcv_flag}, {30'd0, m_flag});
   endtask

   task automatic write_tx(input logic [15:0] d, input logic s, input logic chan);
      int pulses;
      pulses = 0;
      @(negedge clk);
      h_regsel = 1'b0; h_rnw = 1'b0; h_chan = chan;
      tb_data = d; tb_den = 1'b1; tb_sync = s; tb_sden = 1'b1;
      h_strb_n = 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk) h_strb_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (tx_load) pulses++;
         if (k == 3) begin tb_den = 1'b0; tb_sden = 1'b0; end
      end
      h_chan = 1'b0;
      check("R3 single load pulse", pulses, 1);
      check("R3 tx word", {16'd0, tx_word}, {16'd0, d});
      check("R4 sync OR", {31'd0, tx_cmd_sync}, {31'd0, s | m_cfg[4]});
      check("R5 bus OR", {31'd0, tx_bus_b}, {31'd0, chan | m_cfg[5]});
   endtask

   task automatic rx_event(input int ch, input logic good, input logic [15:0] w, input logic c);
      @(negedge clk);
      if (ch == 0) rx_word_a = w; else rx_word_b = w;
      rx_cmd[ch] = c;
      if (good) rx_vld[ch] = 1'b1; else rx_err[ch] = 1'b1;
      @(negedge clk);
      rx_vld = '0; rx_err = '0;
      if (m_cfg[2 + ch]) begin
         if (good) begin
            m_word[ch] = w; m_cmd[ch] = c; m_flag[ch] = 1'b1; m_err[ch] = 1'b0;
         end else m_err[ch] = 1'b1;
      end
      check("R7 R8 rcv_flag", {30'd0, rcv_flag}, {30'd0, m_flag});
      check("R9 err_out", {31'd0, err_out}, {31'd0, |m_err});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      mrst = 1'b1; h_regsel = 0; h_rnw = 1; h_strb_n = 1; h_chan = 0;
      tb_den = 0; tb_sden = 0; tb_sync = 0; tb_data = '0;
      rx_vld = '0; rx_err = '0; rx_cmd = '0; rx_quiet = '0;
      rx_word_a = '0; rx_word_b = '0; tx_ready = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: status during reset
      h_regsel = 1'b1; h_strb_n = 1'b0;
      @(negedge clk);
      check("R1 status in reset", {16'd0, h_data}, 32'h800C);
      h_strb_n = 1'b1; h_regsel = 1'b0;
      @(negedge clk);
      check("R10 data released when idle", {16'd0, h_data}, 32'hFFFF);
      mrst = 1'b0;
      repeat (2) @(negedge clk);
      m_ready = 1'b0;
      read_status("R11 ready follows input");
      tx_ready = 1'b1; m_ready = 1'b1;
      check("R1 flags clear", {29'd0, err_out, rcv_flag}, 32'd0);
      read_rx(1'b0);
      read_rx(1'b1);
      // R2: upper bits ignored
      write_cfg(16'hFFC0 | 16'h000C);
      read_status("R2 upper bits ignored");
      // R8: clear only the register read
      rx_event(0, 1'b1, 16'hA5A5, 1'b1);
      rx_event(1, 1'b1, 16'h5A5A, 1'b0);
      read_rx(1'b1);
      check("R8 other flag kept", {31'd0, rcv_flag[0]}, 32'd1);
      read_status("R11 status after B read");
      // R9: error without flag, cleared by valid word
      rx_event(1, 1'b0, 16'h1111, 1'b0);
      read_status("R9 error bit B");
      rx_event(1, 1'b1, 16'h2222, 1'b1);
      // R7: disabled receiver A
      write_cfg(16'h0008);
      rx_event(0, 1'b1, 16'hDEAD, 1'b0);
      rx_event(0, 1'b0, 16'hBEEF, 1'b0);
      read_rx(1'b0);
      // R6: channel bit selects B with pin low
      write_cfg(16'h002C);
      read_rx(1'b0);
      // R4/R5 directed
      write_cfg(16'h001C);
      write_tx(16'h8001, 1'b0, 1'b0);
      write_cfg(16'h000C);
      write_tx(16'h7FFE, 1'b1, 1'b1);
      write_tx(16'h0000, 1'b0, 1'b0);
      // random mix
      for (int it = 0; it < 300; it++) begin
         int op;
         op = $urandom_range(0, 5);
         rx_quiet = 2'($urandom);
         case (op)
            0: write_cfg(16'($urandom));
            1: write_tx(16'($urandom), 1'($urandom), 1'($urandom));
            2: rx_event(int'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                        16'($urandom), 1'($urandom));
            3: read_rx(1'($urandom));
            default: read_status("R11 random status");
         endcase
      end
      // R1: reset mid-run
      @(negedge clk) mrst = 1'b1;
      @(negedge clk) mrst = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rx_quiet = 2'b00;
      read_status("R1 status after reset");
      read_rx(1'b1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule